// File: doc/BRIEF.md
# I2C Master SCL Rate Generator

This block sets the pace of SCL for an I2C master. A seven-bit divisor, taken from a control register, is loaded into a down counter. The counter moves only on count ticks that the surrounding logic supplies, two per instruction cycle. When the count expires, the block emits a one-cycle rollover strobe, toggles its SCL drive level and, while a transfer is active, reloads itself. An external bit sequencer uses the strobe as its half-period timing base. Two rollovers make one SCL period, so a divisor of N gives an SCL period of 2N count ticks. With a 2 MHz tick rate and N = 3, that is about 333 kHz.

The counter starts when software writes the transmit buffer in master mode. It runs until the sequencer signals that the transfer is done, and then SCL stays at whatever level it had. Before counting a half in which SCL is released, the block waits until the sampled line is actually high, so a slave can stretch the clock. A divisor of zero is refused and reported as a configuration error.

Top module: `sclRateGen`

## Requirements
- R1: After reset, sclOut is 1 (released), busy is 0, rollPulse is 0 and cfgError is 0.
- R2: A bufWrite pulse with masterEn = 1 and a nonzero reloadVal sets busy in the next cycle. A bufWrite with masterEn = 0 has no effect, and busy stays 0.
- R3: Once started with divisor N, rollPulse rises in the clock cycle after the N-th counted phaseTick, stays high for exactly one clock cycle, and then recurs every N counted ticks.
- R4: Each rollover inverts sclOut. The first rollover after a start from the released level drives sclOut to 0. A full SCL period is 2N counted ticks.
- R5: A change to reloadVal while a half-period is being counted does not alter that half. The new value is used from the next reload on.
- R6: A start attempt (bufWrite with masterEn = 1) with reloadVal = 0 sets cfgError to 1, leaves busy at 0 and leaves sclOut unchanged. A later valid start clears cfgError.
- R7: xferDone clears busy in the next cycle and stops counting. sclOut keeps its level, and later ticks give no rollPulse. If xferDone and the final tick of a half arrive in the same cycle, xferDone wins and no rollover occurs.
- R8: While sclOut is 1 and sclIn is 0, ticks are not counted. Counting of that half starts once sclIn reads 1.
- R9: A bufWrite while busy is ignored, and the running half keeps its timing.
- R10: If reloadVal is 0 at an automatic reload, the rollover still happens, then cfgError is set, busy clears and sclOut holds its new level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| masterEn | input | 1 | Master mode is selected |
| reloadVal | input | RELOAD_W | Divisor from the control register |
| bufWrite | input | 1 | Transmit buffer write strobe (start request) |
| phaseTick | input | 1 | Count tick, two per instruction cycle |
| xferDone | input | 1 | Last data bit and acknowledge have finished |
| sclIn | input | 1 | Sampled level of the SCL line |
| rollPulse | output | 1 | One-cycle strobe at each counter rollover |
| sclOut | output | 1 | SCL drive level (1 = released) |
| busy | output | 1 | Counter is active for a transfer |
| cfgError | output | 1 | Divisor of zero was seen at a start or a reload |

## Verification
A counter that loads the wrong value or skips a tick shows up at the first rollover after a start. The rollPulse then lands a tick early or late, which is visible within one half-period of at most 127 ticks. A wrong level register shows up as an inverted sclOut on the strobe that follows. A run flag that is stuck high shows up as strobes that keep coming after xferDone or after a refused zero divisor. Clock stretching that is handled wrongly shows up as a rollover while the line is still held low.

// File: rtl/sclRatePkg.sv
package sclRatePkg;
  localparam int DEF_RELOAD_W = 7;

  typedef struct packed {
    logic load;
    logic dec;
    logic clear;
  } cntCmd_t;
endpackage

// File: rtl/sclRateDp.sv
module sclRateDp
  import sclRatePkg::*;
#(
  parameter int RELOAD_W = DEF_RELOAD_W
) (
  input  logic                clk,
  input  logic                rstN,
  input  cntCmd_t             cmd,
  input  logic [RELOAD_W-1:0] reloadVal,
  output logic                cntLast,
  output logic                cntZero
);
  localparam logic [RELOAD_W-1:0] ONE = {{(RELOAD_W-1){1'b0}}, 1'b1};

  logic [RELOAD_W-1:0] count;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count <= '0;
    end else if (cmd.clear) begin
      count <= '0;
    end else if (cmd.load) begin
      count <= reloadVal;
    end else if (cmd.dec) begin
      count <= count - ONE;
    end
  end

  assign cntLast = (count == ONE);
  assign cntZero = (count == '0);

  // R3: the controller never steps the counter past its last tick
  assert_dec_above_one_R3: assert property (@(posedge clk) disable iff (!rstN)
    cmd.dec |-> (count > ONE));

  // R5: a reload captures the divisor present at that moment
  assert_load_value_R5: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.load && !cmd.clear) |=> (count == $past(reloadVal)));

  // R7: at most one counter command per cycle
  assert_one_cmd_R7: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({cmd.load, cmd.dec, cmd.clear}));
endmodule

// File: rtl/sclRateCtrl.sv
module sclRateCtrl
  import sclRatePkg::*;
#(
  parameter int RELOAD_W = DEF_RELOAD_W
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                masterEn,
  input  logic [RELOAD_W-1:0] reloadVal,
  input  logic                bufWrite,
  input  logic                phaseTick,
  input  logic                xferDone,
  input  logic                sclIn,
  input  logic                cntLast,
  input  logic                cntZero,
  output cntCmd_t             cmd,
  output logic                rollPulse,
  output logic                sclOut,
  output logic                busy,
  output logic                cfgError
);
  logic reloadIsZero;
  logic startReq;
  logic startOk;
  logic startBad;
  logic stretchOk;
  logic stepNow;
  logic rollNow;
  logic reloadBad;
  logic stopNow;

  assign reloadIsZero = (reloadVal == '0);
  assign startReq     = bufWrite & masterEn & ~busy;
  assign startOk      = startReq & ~reloadIsZero;
  assign startBad     = startReq & reloadIsZero;
  // a released half waits for the wire to really be high
  assign stretchOk    = ~sclOut | sclIn;
  assign stepNow      = busy & phaseTick & stretchOk & ~xferDone;
  assign rollNow      = stepNow & cntLast;
  assign reloadBad    = rollNow & reloadIsZero;
  assign stopNow      = (busy & xferDone) | reloadBad;

  always_comb begin
    cmd       = '0;
    cmd.clear = stopNow;
    cmd.load  = startOk | (rollNow & ~reloadBad);
    cmd.dec   = stepNow & ~cntLast;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy      <= 1'b0;
      sclOut    <= 1'b1;
      rollPulse <= 1'b0;
      cfgError  <= 1'b0;
    end else begin
      rollPulse <= rollNow;
      if (rollNow) begin
        sclOut <= ~sclOut;
      end
      if (startOk) begin
        busy <= 1'b1;
      end else if (stopNow) begin
        busy <= 1'b0;
      end
      if (startBad || reloadBad) begin
        cfgError <= 1'b1;
      end else if (startOk) begin
        cfgError <= 1'b0;
      end
    end
  end

  // R4: every strobe comes with a freshly inverted SCL level
  assert_roll_toggles_R4: assert property (@(posedge clk) disable iff (!rstN)
    rollPulse |-> (sclOut != $past(sclOut)));

  // R2: while busy the counter always holds a live value
  assert_busy_live_count_R2: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !cntZero);

  // R8: no rollover while a released line is held low
  assert_stretch_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    (busy && sclOut && !sclIn) |=> !rollPulse);

  // R7: an idle generator keeps SCL where it was
  assert_idle_scl_R7: assert property (@(posedge clk) disable iff (!rstN)
    !busy |=> $stable(sclOut));

  // R6: a zero divisor never starts the counter
  assert_zero_nostart_R6: assert property (@(posedge clk) disable iff (!rstN)
    (bufWrite && masterEn && !busy && (reloadVal == '0)) |=> (!busy && cfgError));
endmodule

// File: rtl/sclRateGen.sv
module sclRateGen
  import sclRatePkg::*;
#(
  parameter int RELOAD_W = DEF_RELOAD_W
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                masterEn,
  input  logic [RELOAD_W-1:0] reloadVal,
  input  logic                bufWrite,
  input  logic                phaseTick,
  input  logic                xferDone,
  input  logic                sclIn,
  output logic                rollPulse,
  output logic                sclOut,
  output logic                busy,
  output logic                cfgError
);
  cntCmd_t cmd;
  logic    cntLast;
  logic    cntZero;

  sclRateCtrl #(.RELOAD_W(RELOAD_W)) ctrlInst (
    .clk       (clk),
    .rstN      (rstN),
    .masterEn  (masterEn),
    .reloadVal (reloadVal),
    .bufWrite  (bufWrite),
    .phaseTick (phaseTick),
    .xferDone  (xferDone),
    .sclIn     (sclIn),
    .cntLast   (cntLast),
    .cntZero   (cntZero),
    .cmd       (cmd),
    .rollPulse (rollPulse),
    .sclOut    (sclOut),
    .busy      (busy),
    .cfgError  (cfgError)
  );

  sclRateDp #(.RELOAD_W(RELOAD_W)) dpInst (
    .clk       (clk),
    .rstN      (rstN),
    .cmd       (cmd),
    .reloadVal (reloadVal),
    .cntLast   (cntLast),
    .cntZero   (cntZero)
  );
endmodule

// File: tb/sclRateGen_test.sv
`timescale 1ns/1ps
module sclRateGen_test;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       masterEn = 1'b0;
  logic [6:0] reloadVal = 7'd0;
  logic       bufWrite = 1'b0;
  logic       phaseTick = 1'b0;
  logic       xferDone = 1'b0;
  logic       holdLow = 1'b0;
  logic       sclIn;
  logic       rollPulse, sclOut, busy, cfgError;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  // open-drain wire: a slave may hold it low
  assign sclIn = sclOut & ~holdLow;

  always #2.5 clk = ~clk;

  sclRateGen #(.RELOAD_W(7)) uut (
    .clk(clk), .rstN(rstN), .masterEn(masterEn), .reloadVal(reloadVal),
    .bufWrite(bufWrite), .phaseTick(phaseTick), .xferDone(xferDone),
    .sclIn(sclIn), .rollPulse(rollPulse), .sclOut(sclOut), .busy(busy),
    .cfgError(cfgError)
  );

  localparam int NVEC = 6;
  localparam logic [6:0] VEC_RELOAD [NVEC] = '{7'd1, 7'd2, 7'd3, 7'd5, 7'h0D, 7'h7F};

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic tickOnce(output bit rolled);
    phaseTick = 1'b1;
    cyc();
    phaseTick = 1'b0;
    rolled = rollPulse;
    cyc();
  endtask

  task automatic startXfer(input logic [6:0] n);
    reloadVal = n;
    bufWrite = 1'b1;
    cyc();
    bufWrite = 1'b0;
  endtask

  task automatic stopXfer();
    xferDone = 1'b1;
    cyc();
    xferDone = 1'b0;
  endtask

  task automatic measureHalf(output int n);
    bit r;
    n = 0;
    r = 1'b0;
    while (!r && n < 300) begin
      tickOnce(r);
      n++;
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin : main
    int n;
    bit r;
    bit lvl;
    cyc();
    cyc();
    // R1 reset state
    check(sclOut == 1'b1, "R1 sclOut", sclOut, 1);
    check(busy == 1'b0, "R1 busy", busy, 0);
    check(rollPulse == 1'b0, "R1 rollPulse", rollPulse, 0);
    check(cfgError == 1'b0, "R1 cfgError", cfgError, 0);
    rstN = 1'b1;
    cyc();

    // R2 start is ignored outside master mode
    startXfer(7'd3);
    check(busy == 1'b0, "R2 no start without masterEn", busy, 0);
    masterEn = 1'b1;

    // table walk: R2 R3 R4 for several divisors
    for (int v = 0; v < NVEC; v++) begin
      startXfer(VEC_RELOAD[v]);
      check(busy == 1'b1, "R2 busy after start", busy, 1);
      measureHalf(n);
      check(n == int'(VEC_RELOAD[v]), "R3 low half ticks", n, int'(VEC_RELOAD[v]));
      check(sclOut == 1'b0, "R4 first rollover drives low", sclOut, 0);
      check(rollPulse == 1'b0, "R3 strobe lasts one cycle", rollPulse, 0);
      measureHalf(n);
      check(n == int'(VEC_RELOAD[v]), "R3 high half ticks", n, int'(VEC_RELOAD[v]));
      check(sclOut == 1'b1, "R4 second rollover releases", sclOut, 1);
      stopXfer();
      check(busy == 1'b0, "R7 busy clears on done", busy, 0);
    end

    // R6 zero divisor refused
    startXfer(7'd0);
    check(cfgError == 1'b1, "R6 cfgError set", cfgError, 1);
    check(busy == 1'b0, "R6 no start", busy, 0);
    check(sclOut == 1'b1, "R6 scl unchanged", sclOut, 1);
    for (int i = 0; i < 4; i++) begin
      tickOnce(r);
      check(r == 1'b0, "R6 no strobe after refused start", r, 0);
    end
    startXfer(7'd2);
    check(cfgError == 1'b0, "R6 valid start clears error", cfgError, 0);
    stopXfer();

    // R5 divisor change mid-half applies at next reload
    startXfer(7'd4);
    tickOnce(r);
    reloadVal = 7'd2;
    measureHalf(n);
    check(n == 3, "R5 running half keeps old divisor", n + 1, 4);
    measureHalf(n);
    check(n == 2, "R5 next half uses new divisor", n, 2);
    stopXfer();

    // R9 buffer write while busy ignored
    startXfer(7'd3);
    tickOnce(r);
    bufWrite = 1'b1;
    cyc();
    bufWrite = 1'b0;
    measureHalf(n);
    check(n == 2, "R9 restart ignored", n + 1, 3);
    check(sclOut == 1'b0, "R9 scl low", sclOut, 0);

    // R8 stretch on the released half
    measureHalf(n);
    holdLow = 1'b0;
    check(sclOut == 1'b1, "R8 released", sclOut, 1);
    holdLow = 1'b1;
    for (int i = 0; i < 6; i++) begin
      tickOnce(r);
      check(r == 1'b0, "R8 no count while held low", r, 0);
    end
    holdLow = 1'b0;
    measureHalf(n);
    check(n == 3, "R8 full half after release", n, 3);
    check(sclOut == 1'b0, "R8 low after stretched half", sclOut, 0);

    // R7 done holds SCL low, no further strobes
    stopXfer();
    lvl = sclOut;
    for (int i = 0; i < 10; i++) begin
      tickOnce(r);
      check(r == 1'b0, "R7 no strobe after done", r, 0);
    end
    check(sclOut == lvl, "R7 scl holds", sclOut, lvl);
    // restart from held low: low half needs no wait, first rollover releases
    startXfer(7'd2);
    measureHalf(n);
    check(n == 2 && sclOut == 1'b1, "R4 restart from low toggles high", n, 2);
    stopXfer();

    // R7 done wins over a coincident final tick
    startXfer(7'd1);
    phaseTick = 1'b1;
    xferDone = 1'b1;
    cyc();
    phaseTick = 1'b0;
    xferDone = 1'b0;
    check(rollPulse == 1'b0, "R7 coincident done no strobe", rollPulse, 0);
    check(sclOut == 1'b1, "R7 coincident done scl holds", sclOut, 1);
    check(busy == 1'b0, "R7 coincident done stops", busy, 0);

    // R10 zero divisor at automatic reload
    startXfer(7'd2);
    reloadVal = 7'd0;
    measureHalf(n);
    check(n == 2, "R10 last half completes", n, 2);
    check(cfgError == 1'b1, "R10 cfgError set", cfgError, 1);
    check(busy == 1'b0, "R10 stopped", busy, 0);
    check(sclOut == 1'b0, "R10 scl holds new level", sclOut, 0);
    for (int i = 0; i < 5; i++) begin
      tickOnce(r);
      check(r == 1'b0, "R10 no strobe after stop", r, 0);
    end

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule